// File: doc/BRIEF.md
# Upper Memory Shadow Region Decoder

This block holds a small bank of configuration registers behind an index/data pair of I/O ports, and from those registers it decides, for each 16 KB page of the upper memory area, where a read goes and where a write goes: to the internal DRAM or out to the external expansion bus. Software first writes a register number to the index port, then reads or writes that register through the data port.

The router looks only at the page number of a memory access (address bits 19:14). It returns two flags, one for the read direction and one for the write direction, each set when that direction is served internally. The ROM-extension window (C0000–CFFFF) and the BIOS window (F0000–FFFFF) are always decoded. The enhanced variant, chosen by a parameter, also implements a second register range that controls the D0000–DFFFF and E0000–EFFFF windows. In the base variant that range is absent and those windows stay on the external bus.

Top module: `umb_shadow_decoder`

## Requirements
- R1: After reset every configuration register and the index register hold 0x00. With that state, C0000–EFFFF routes externally for both directions, and F0000–FFFFF reads externally and writes internally.
- R2: An I/O write to port 0x22 loads the index. A write to port 0x23 stores the data into the register the index selects. A read with io_rd high at port 0x23 returns that register in the same cycle.
- R3: io_rdata is 0xFF whenever io_rd is low or io_addr is not 0x23. This includes reads of the index port.
- R4: Registers exist at indexes 0x10–0x1F, and at 0x60–0x7F only when ENHANCED=1. Writes to any other index are ignored, and reads of any other index return 0x00. In the base variant the D and E windows therefore always route externally.
- R5: Register 0x15 bit 7 set routes F0000–FFFFF reads internal and writes external. Clear routes reads external and writes internal.
- R6: Register 0x15 bit 0 set makes every page of C0000–CFFFF external for both directions, whatever its other bits hold.
- R7: Otherwise, bits 2, 3, 4 and 5 of register 0x15 enable the pages at C0000, C4000, C8000 and CC000. For an enabled page, bit 1 set gives read-internal/write-external, and bit 1 clear gives read-external/write-internal.
- R8: A page whose enable bit is clear routes externally for both directions.
- R9: With ENHANCED=1, registers 0x6E and 0x6F govern D0000–DFFFF and E0000–EFFFF with the same bit positions as register 0x15. Bit 1 clear on an enabled page gives read-internal/write-internal, and bit 1 set gives read-internal/write-external.
- R10: Every page below C0000 routes externally for both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, sampled on the rising edge |
| io_rd | input | 1 | I/O read strobe, qualifies io_rdata |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| mem_seg | input | 6 | Memory address bits 19:14 (16 KB page number) |
| rd_internal | output | 1 | Read of this page is served by internal DRAM |
| wr_internal | output | 1 | Write of this page is served by internal DRAM |

## Verification
On every cycle, the assertions check several things: the BIOS window always splits the two directions against the select bit, the pass-through bit and a cleared page enable force external routing, and low pages never route inside. They also check that the index port loads on a write, and that unimplemented indexes and foreign ports read back 0xFF or 0x00 as required. Some behaviour only the bench's sweeps can show. For every value of the three window registers, each page must receive the right combination of directions. The D and E windows must use their different bit-1 meaning. Stored data must read back at exactly the implemented indexes, and the base variant must drop its upper range.

// File: rtl/umb_pkg.sv
package umb_pkg;

  localparam int SEGS_PER_WIN = 4;
  localparam int SEG_W        = $clog2(SEGS_PER_WIN);
  localparam int CFG_W        = 2 + SEGS_PER_WIN;

  typedef struct packed {
    logic rd_int;
    logic wr_int;
  } route_t;

  localparam route_t ROUTE_EXT = '{rd_int: 1'b0, wr_int: 1'b0};

  // BIOS window: the two directions always go to opposite sides.
  function automatic route_t bios_route(input logic rd_sel);
    route_t r;
    r.rd_int = rd_sel;
    r.wr_int = !rd_sel;
    return r;
  endfunction

  // Shadow window: cfg[0] pass-through, cfg[1] mode, cfg[CFG_W-1:2] page enables.
  // clr_both selects the meaning of mode-clear (both internal vs. write-only internal).
  function automatic route_t shadow_route(input logic [CFG_W-1:0] cfg,
                                          input logic [SEG_W-1:0] seg,
                                          input logic clr_both);
    route_t r;
    logic [SEGS_PER_WIN-1:0] en;
    en = cfg[CFG_W-1:2];
    r  = ROUTE_EXT;
    if (!cfg[0] && en[seg]) begin
      r.rd_int = cfg[1] | clr_both;
      r.wr_int = !cfg[1];
    end
    return r;
  endfunction

endpackage

// File: rtl/umb_cfg_regs.sv
module umb_cfg_regs
  import umb_pkg::*;
#(
  parameter bit         ENHANCED   = 1'b1,
  parameter logic [7:0] INDEX_PORT = 8'h22,
  parameter logic [7:0] DATA_PORT  = 8'h23,
  parameter logic [7:0] LOW_BASE   = 8'h10,
  parameter int         LOW_CNT    = 16,
  parameter logic [7:0] HIGH_BASE  = 8'h60,
  parameter int         HIGH_CNT   = 32,
  parameter logic [7:0] C_REG      = 8'h15,
  parameter logic [7:0] D_REG      = 8'h6E,
  parameter logic [7:0] E_REG      = 8'h6F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [7:0]       io_addr,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  output logic [CFG_W-1:0] cfg_c,
  output logic [CFG_W-1:0] cfg_d,
  output logic [CFG_W-1:0] cfg_e,
  output logic             bios_rd_int
);

  localparam int C_SLOT = int'(C_REG) - int'(LOW_BASE);

  logic [7:0] index_q;
  logic       idx_wr;
  logic       data_wr;
  logic       data_rd;
  logic [7:0] low_q [LOW_CNT];
  logic [7:0] low_rd;
  logic       low_hit;
  logic [7:0] high_rd;
  logic       high_hit;

  assign idx_wr  = io_wr && (io_addr == INDEX_PORT);
  assign data_wr = io_wr && (io_addr == DATA_PORT);
  assign data_rd = io_rd && (io_addr == DATA_PORT);

  always_ff @(posedge clk) begin
    if (!rst_n)      index_q <= '0;
    else if (idx_wr) index_q <= io_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LOW_CNT; i++) low_q[i] <= '0;
    end else begin
      for (int i = 0; i < LOW_CNT; i++)
        if (data_wr && (index_q == 8'(int'(LOW_BASE) + i))) low_q[i] <= io_wdata;
    end
  end

  always_comb begin
    low_rd  = '0;
    low_hit = 1'b0;
    for (int i = 0; i < LOW_CNT; i++)
      if (index_q == 8'(int'(LOW_BASE) + i)) begin
        low_hit = 1'b1;
        low_rd  = low_q[i];
      end
  end

  assign cfg_c       = low_q[C_SLOT][CFG_W-1:0];
  assign bios_rd_int = low_q[C_SLOT][7];

  generate
    if (ENHANCED) begin : g_high
      localparam int D_SLOT = int'(D_REG) - int'(HIGH_BASE);
      localparam int E_SLOT = int'(E_REG) - int'(HIGH_BASE);
      logic [7:0] high_q [HIGH_CNT];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < HIGH_CNT; i++) high_q[i] <= '0;
        end else begin
          for (int i = 0; i < HIGH_CNT; i++)
            if (data_wr && (index_q == 8'(int'(HIGH_BASE) + i))) high_q[i] <= io_wdata;
        end
      end

      always_comb begin
        high_rd  = '0;
        high_hit = 1'b0;
        for (int i = 0; i < HIGH_CNT; i++)
          if (index_q == 8'(int'(HIGH_BASE) + i)) begin
            high_hit = 1'b1;
            high_rd  = high_q[i];
          end
      end

      assign cfg_d = high_q[D_SLOT][CFG_W-1:0];
      assign cfg_e = high_q[E_SLOT][CFG_W-1:0];
    end else begin : g_no_high
      assign high_rd  = '0;
      assign high_hit = 1'b0;
      assign cfg_d    = '0;
      assign cfg_e    = '0;
    end
  endgenerate

  assign io_rdata = data_rd ? (low_rd | high_rd) : 8'hFF;

  // R2: the index port captures the written byte
  assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (index_q == $past(io_wdata)));

  // R3: anything but a qualified data-port read floats high
  assert_idle_ff_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd |-> (io_rdata == 8'hFF));

  // R4: an index with no register behind it reads as zero
  assert_unimpl_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !low_hit && !high_hit) |-> (io_rdata == 8'h00));

  // R4: the two register ranges never overlap
  assert_single_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(low_hit && high_hit));

endmodule

// File: rtl/umb_region_router.sv
module umb_region_router
  import umb_pkg::*;
#(
  parameter int PAGE_W    = 6,
  parameter int FIRST_WIN = 12,
  parameter int NWIN      = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PAGE_W-1:0]          page,
  input  logic [NWIN-1:0][CFG_W-1:0] cfg_win,
  input  logic                       bios_rd_int,
  output route_t                     route
);

  localparam int WIN_W    = PAGE_W - SEG_W;
  localparam int BIOS_WIN = FIRST_WIN + NWIN;

  logic [WIN_W-1:0]        win_idx;
  logic [SEG_W-1:0]        seg;
  route_t                  win_rt [NWIN];
  logic                    in_low;
  logic                    in_bios;
  logic                    in_shadow;
  logic [CFG_W-1:0]        cur_cfg;
  logic [SEGS_PER_WIN-1:0] cur_en;
  logic                    pass_hit;
  logic                    seg_off;
  route_t                  route_sel;

  assign win_idx = page[PAGE_W-1:SEG_W];
  assign seg     = page[SEG_W-1:0];
  assign in_low  = win_idx < WIN_W'(FIRST_WIN);
  assign in_bios = win_idx == WIN_W'(BIOS_WIN);

  // Window 0 (ROM extension) treats mode-clear as write-only internal;
  // the later windows treat it as fully internal.
  generate
    for (genvar w = 0; w < NWIN; w++) begin : g_win
      localparam bit CLR_BOTH = (w != 0);
      assign win_rt[w] = shadow_route(cfg_win[w], seg, CLR_BOTH);
    end
  endgenerate

  always_comb begin
    in_shadow = 1'b0;
    cur_cfg   = '0;
    route_sel = ROUTE_EXT;
    for (int w = 0; w < NWIN; w++)
      if (win_idx == WIN_W'(FIRST_WIN + w)) begin
        in_shadow = 1'b1;
        cur_cfg   = cfg_win[w];
        route_sel = win_rt[w];
      end
    if (in_bios) route_sel = bios_route(bios_rd_int);
  end

  assign cur_en   = cur_cfg[CFG_W-1:2];
  assign pass_hit = in_shadow && cur_cfg[0];
  assign seg_off  = in_shadow && !cur_cfg[0] && !cur_en[seg];
  assign route    = route_sel;

  // R5: BIOS window sends the two directions to opposite sides
  assert_bios_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_bios |-> ((route.rd_int == bios_rd_int) && (route.wr_int == !bios_rd_int)));

  // R6: pass-through bit wins over every page enable
  assert_pass_external_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pass_hit |-> (route == ROUTE_EXT));

  // R8: a disabled page is external both ways
  assert_seg_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seg_off |-> (route == ROUTE_EXT));

  // R10: conventional memory below the shadow windows is never claimed
  assert_low_external_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_low |-> (route == ROUTE_EXT));

  // R7/R9: an enabled shadow page always reads or writes internally
  assert_enabled_claims_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_shadow && !pass_hit && !seg_off) |-> (route.rd_int || route.wr_int));

endmodule

// File: rtl/umb_shadow_decoder.sv
module umb_shadow_decoder
  import umb_pkg::*;
#(
  parameter bit         ENHANCED   = 1'b1,
  parameter logic [7:0] INDEX_PORT = 8'h22,
  parameter logic [7:0] DATA_PORT  = 8'h23
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr,
  input  logic       io_rd,
  input  logic [7:0] io_addr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  input  logic [5:0] mem_seg,
  output logic       rd_internal,
  output logic       wr_internal
);

  localparam int NWIN = 3;

  logic [CFG_W-1:0]           cfg_c;
  logic [CFG_W-1:0]           cfg_d;
  logic [CFG_W-1:0]           cfg_e;
  logic                       bios_rd_int;
  logic [NWIN-1:0][CFG_W-1:0] cfg_win;
  route_t                     route;

  umb_cfg_regs #(
    .ENHANCED  (ENHANCED),
    .INDEX_PORT(INDEX_PORT),
    .DATA_PORT (DATA_PORT)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_addr    (io_addr),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .cfg_c      (cfg_c),
    .cfg_d      (cfg_d),
    .cfg_e      (cfg_e),
    .bios_rd_int(bios_rd_int)
  );

  assign cfg_win = {cfg_e, cfg_d, cfg_c};

  umb_region_router #(
    .PAGE_W   (6),
    .FIRST_WIN(12),
    .NWIN     (NWIN)
  ) u_router (
    .clk        (clk),
    .rst_n      (rst_n),
    .page       (mem_seg),
    .cfg_win    (cfg_win),
    .bios_rd_int(bios_rd_int),
    .route      (route)
  );

  assign rd_internal = route.rd_int;
  assign wr_internal = route.wr_int;

endmodule

// File: tb/umb_shadow_decoder_tb.sv
`timescale 1ns/1ps
module umb_shadow_decoder_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_wr = 1'b0;
  logic       io_rd = 1'b0;
  logic [7:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic [5:0] mem_seg = '0;
  logic [7:0] rdata_e, rdata_b;
  logic       rd_e, wr_e, rd_b, wr_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state kept by the bench
  int m15 = 0, m6e = 0, m6f = 0;

  always #4 clk = ~clk;

  umb_shadow_decoder #(.ENHANCED(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(rdata_e), .mem_seg(mem_seg),
    .rd_internal(rd_e), .wr_internal(wr_e));

  umb_shadow_decoder #(.ENHANCED(1'b0)) u_dut_base (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(rdata_b), .mem_seg(mem_seg),
    .rd_internal(rd_b), .wr_internal(wr_b));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] idx, input logic [7:0] d);
    io_write(8'h22, idx);
    io_write(8'h23, d);
  endtask

  task automatic io_read(input logic [7:0] a, input logic rd, output logic [7:0] ve, output logic [7:0] vb);
    @(negedge clk);
    io_rd = rd; io_addr = a;
    #1;
    ve = rdata_e; vb = rdata_b;
    io_rd = 1'b0;
  endtask

  // expected {rd_internal, wr_internal} per page, from the requirements
  function automatic int exp_route(input int page, input bit enh);
    int win, sg, cfg;
    win = page / 4;
    sg  = page % 4;
    if (win < 12) return 0;                                   // R10
    if (win == 15) return ((m15 / 128) % 2 == 1) ? 2 : 1;     // R5
    if (win == 12) cfg = m15;
    else if (win == 13) cfg = enh ? m6e : 0;                  // R4/R9
    else cfg = enh ? m6f : 0;
    if (cfg % 2 == 1) return 0;                               // R6
    if (((cfg >> (sg + 2)) % 2) == 0) return 0;               // R8
    if (((cfg / 2) % 2) == 1) return 2;                       // R7/R9 mode set
    return (win == 12) ? 1 : 3;                               // R7 vs R9 mode clear
  endfunction

  function automatic int exp_reg(input int idx, input bit enh);
    if (idx >= 8'h10 && idx <= 8'h1F) return idx ^ 8'hA5;
    if (enh && idx >= 8'h60 && idx <= 8'h7F) return idx ^ 8'hA5;
    return 0;
  endfunction

  task automatic sweep_pages(input string req, input int lo, input int hi);
    for (int p = lo; p <= hi; p++) begin
      @(negedge clk);
      mem_seg = 6'(p);
      #1;
      check(req, {rd_e, wr_e}, exp_route(p, 1'b1));
      check(req, {rd_b, wr_b}, exp_route(p, 1'b0));
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ve, vb;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    io_read(8'h23, 1'b1, ve, vb);
    check("R1 index0", ve, 0);
    check("R1 index0 base", vb, 0);
    io_write(8'h22, 8'h15);
    io_read(8'h23, 1'b1, ve, vb);
    check("R1 reg15", ve, 0);
    io_write(8'h22, 8'h6E);
    io_read(8'h23, 1'b1, ve, vb);
    check("R1 reg6E", ve, 0);
    sweep_pages("R1 routes", 0, 63);

    // R3: foreign ports and idle strobe
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h23) begin
        io_read(8'(a), 1'b1, ve, vb);
        check("R3 port", ve, 8'hFF);
        check("R3 port base", vb, 8'hFF);
      end
    end
    io_read(8'h23, 1'b0, ve, vb);
    check("R3 no strobe", ve, 8'hFF);

    // R2/R4: store and read back every index
    for (int i = 0; i < 256; i++) set_reg(8'(i), 8'(i ^ 8'hA5));
    for (int i = 0; i < 256; i++) begin
      io_write(8'h22, 8'(i));
      io_read(8'h23, 1'b1, ve, vb);
      check("R2 readback", ve, exp_reg(i, 1'b1));
      check("R4 base readback", vb, exp_reg(i, 1'b0));
    end
    set_reg(8'h15, 8'h00); set_reg(8'h6E, 8'h00); set_reg(8'h6F, 8'h00);
    m15 = 0; m6e = 0; m6f = 0;

    // R5-R8, R10: every value of the ROM/BIOS register
    for (int v = 0; v < 256; v++) begin
      set_reg(8'h15, 8'(v));
      m15 = v;
      sweep_pages("R5-8 C/F", 48, 51);
      sweep_pages("R5 bios", 60, 63);
      sweep_pages("R10 low", 47, 47);
    end
    set_reg(8'h15, 8'h00); m15 = 0;

    // R9/R4: D window register
    for (int v = 0; v < 256; v++) begin
      set_reg(8'h6E, 8'(v));
      m6e = v;
      sweep_pages("R9 D", 52, 55);
    end
    // R9/R4: E window register
    for (int v = 0; v < 256; v++) begin
      set_reg(8'h6F, 8'(v));
      m6f = v;
      sweep_pages("R9 E", 56, 59);
    end
    // R2: index write must not disturb stored data
    io_write(8'h22, 8'h6F);
    io_read(8'h23, 1'b1, ve, vb);
    check("R2 final reg6F", ve, 8'hFF);
    check("R4 final base", vb, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule